// File: doc/BRIEF.md
# Literal and Route Latch Updater

This block owns three pieces of state in a dock: the 37-bit data latch, the 13-bit outgoing route latch, and the 13-bit latch that holds the route for torpedo acknowledgments. It watches instructions as they arrive on deck and as they execute, and it updates those latches for the instructions that build constants and the move forms that set the route. Counters, flags and fabric handshakes belong to other blocks.

An instruction is presented on `insn_in` with a one-cycle `deck_load` strobe. In that same edge the block stores the decoded fields and an extended literal in an internal on-deck register. A later `exec_fire` strobe commits that stored instruction once. An instruction whose predicate fails is never fired. It is simply overwritten by the next `deck_load` and leaves every latch as it was. Wide constants are built by a chain of shift instructions, each of which pushes 19 new bits into the low end of the data latch.

Top module: `lpl_latch_updater`

## Requirements
- R1: While `rst_n` is low, and after reset, `data_latch`, `route_latch` and `ack_route_latch` all read zero.
- R2: Instruction class is held in bits 25:24 (00 shift, 01 set, 10 move, 11 none). When a shift executes, `data_latch` becomes its previous low 18 bits in positions 36:19, with the instruction's bits 18:0 in positions 18:0.
- R3: A set instruction carries its target code in bits 23:19 and its immediate in bits 12:0. Target 0 loads `data_latch` with the immediate extended with zeros.
- R4: Set target 1 loads `data_latch` with the immediate extended with ones, so bits 36:13 are all ones.
- R5: The literal and fields used at execution are the ones present on `insn_in` at the `deck_load` edge. Later changes on `insn_in` have no effect on the result.
- R6: With no `exec_fire`, no latch changes. An on-deck instruction that is replaced by a new `deck_load` before it fires leaves no trace.
- R7: A move whose route mode (bits 14:13) is 01 loads `route_latch` with its bits 12:0.
- R8: A move with route mode 10 loads `route_latch` with bits 36:24 of `data_in` sampled at the `exec_fire` edge.
- R9: A move with bit 15 set loads `data_latch` from `data_in`. Route modes 00 and 11 leave `route_latch` unchanged.
- R10: Set target 2 loads `ack_route_latch` with the 13-bit immediate.
- R11: Each on-deck instruction takes effect at most once. An `exec_fire` while nothing is on deck, or a second one after the first, changes nothing.
- R12: Class 11, and set targets other than 0, 1 and 2, change no latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| deck_load | input | 1 | Instruction on `insn_in` comes on deck |
| insn_in | input | 26 | Instruction word |
| exec_fire | input | 1 | Execute the on-deck instruction |
| data_in | input | 37 | Incoming data word from the predecessor |
| data_latch | output | 37 | Data latch contents |
| route_latch | output | 13 | Outgoing route latch |
| ack_route_latch | output | 13 | Torpedo acknowledgment route latch |

## Verification
The hardest situation to reach is one where the on-deck contents differ from what is on `insn_in` at the moment of execution. This covers two cases: a literal captured earlier and then committed against a changed input word, and an on-deck instruction that is replaced without ever firing. The directed tests reach both cases. They change `insn_in` in the same cycle as `exec_fire`, and they issue two `deck_load` strobes back to back, checking the latches between the two. Shift chains are run back to back so that the bits carried from the low end to the high end can be checked against a model held in the bench.

// File: rtl/lpl_pkg.sv
package lpl_pkg;
  typedef enum logic [1:0] {
    OP_SHIFT = 2'b00,
    OP_SET   = 2'b01,
    OP_MOVE  = 2'b10,
    OP_NONE  = 2'b11
  } op_e;

  localparam logic [1:0] ROUTE_KEEP = 2'b00;
  localparam logic [1:0] ROUTE_IMM  = 2'b01;
  localparam logic [1:0] ROUTE_DATA = 2'b10;

  localparam int TGT_DL_ZERO = 0;
  localparam int TGT_DL_ONES = 1;
  localparam int TGT_ACK     = 2;
endpackage

// File: rtl/lpl_deck_stage.sv
module lpl_deck_stage
  import lpl_pkg::*;
#(
  parameter int INSN_W  = 26,
  parameter int WORD_W  = 37,
  parameter int SHIFT_W = 19,
  parameter int IMM_W   = 13,
  localparam int TGT_W  = INSN_W - 2 - SHIFT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deck_load,
  input  logic [INSN_W-1:0] insn_in,
  input  logic              exec_fire,
  output op_e               od_op,
  output logic [TGT_W-1:0]  od_tgt,
  output logic [1:0]        od_route,
  output logic              od_cap,
  output logic [WORD_W-1:0] od_lit,
  output logic              act
);
  logic od_full;

  function automatic logic [WORD_W-1:0] extend_literal(input logic [INSN_W-1:0] w);
    logic [WORD_W-1:0] r;
    r = '0;
    if (op_e'(w[INSN_W-1 -: 2]) == OP_SHIFT)
      r[SHIFT_W-1:0] = w[SHIFT_W-1:0];
    else if (op_e'(w[INSN_W-1 -: 2]) == OP_SET &&
             w[INSN_W-3 -: TGT_W] == TGT_W'(TGT_DL_ONES))
      r = {{(WORD_W-IMM_W){1'b1}}, w[IMM_W-1:0]};
    else
      r[IMM_W-1:0] = w[IMM_W-1:0];
    return r;
  endfunction

  assign act = exec_fire && od_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      od_full  <= 1'b0;
      od_op    <= OP_NONE;
      od_tgt   <= '0;
      od_route <= ROUTE_KEEP;
      od_cap   <= 1'b0;
      od_lit   <= '0;
    end else begin
      if (deck_load) begin
        od_full  <= 1'b1;
        od_op    <= op_e'(insn_in[INSN_W-1 -: 2]);
        od_tgt   <= insn_in[INSN_W-3 -: TGT_W];
        od_route <= insn_in[IMM_W+1:IMM_W];
        od_cap   <= insn_in[IMM_W+2];
        od_lit   <= extend_literal(insn_in);
      end else if (act) begin
        od_full <= 1'b0;
      end
    end
  end

  assert_deck_fills_R11: assert property (@(posedge clk) disable iff (!rst_n)
    deck_load |=> od_full);
  assert_fire_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !deck_load) |=> !act);
endmodule

// File: rtl/lpl_data_latch.sv
module lpl_data_latch #(
  parameter int WORD_W  = 37,
  parameter int SHIFT_W = 19,
  localparam int KEEP_W = WORD_W - SHIFT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_shift,
  input  logic              ev_load_lit,
  input  logic              ev_capture,
  input  logic [WORD_W-1:0] lit,
  input  logic [WORD_W-1:0] data_in,
  output logic [WORD_W-1:0] q
);
  function automatic logic [WORD_W-1:0] shift_in(input logic [WORD_W-1:0] old,
                                                  input logic [SHIFT_W-1:0] chunk);
    return {old[KEEP_W-1:0], chunk};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)           q <= '0;
    else if (ev_shift)    q <= shift_in(q, lit[SHIFT_W-1:0]);
    else if (ev_load_lit) q <= lit;
    else if (ev_capture)  q <= data_in;
  end

  assert_dl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_shift || ev_load_lit || ev_capture) |=> $stable(q));
  assert_dl_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_shift |=> q[WORD_W-1:SHIFT_W] == $past(q[KEEP_W-1:0]));
  assert_dl_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_shift, ev_load_lit, ev_capture}));
endmodule

// File: rtl/lpl_route_latch.sv
module lpl_route_latch #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= value;
  end

  assert_route_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
  assert_route_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q == $past(value));
endmodule

// File: rtl/lpl_latch_updater.sv
module lpl_latch_updater
  import lpl_pkg::*;
#(
  parameter int INSN_W  = 26,
  parameter int WORD_W  = 37,
  parameter int SHIFT_W = 19,
  parameter int IMM_W   = 13,
  parameter int ROUTE_W = 13,
  localparam int TGT_W  = INSN_W - 2 - SHIFT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               deck_load,
  input  logic [INSN_W-1:0]  insn_in,
  input  logic               exec_fire,
  input  logic [WORD_W-1:0]  data_in,
  output logic [WORD_W-1:0]  data_latch,
  output logic [ROUTE_W-1:0] route_latch,
  output logic [ROUTE_W-1:0] ack_route_latch
);
  op_e               od_op;
  logic [TGT_W-1:0]  od_tgt;
  logic [1:0]        od_route;
  logic              od_cap;
  logic [WORD_W-1:0] od_lit;
  logic              act;

  lpl_deck_stage #(.INSN_W(INSN_W), .WORD_W(WORD_W), .SHIFT_W(SHIFT_W), .IMM_W(IMM_W)) u_deck (
    .clk(clk), .rst_n(rst_n), .deck_load(deck_load), .insn_in(insn_in),
    .exec_fire(exec_fire), .od_op(od_op), .od_tgt(od_tgt), .od_route(od_route),
    .od_cap(od_cap), .od_lit(od_lit), .act(act)
  );

  logic ev_shift, ev_load_lit, ev_set_ack, ev_capture, ev_route_imm, ev_route_data;
  logic [ROUTE_W-1:0] route_next;

  assign ev_shift      = act && od_op == OP_SHIFT;
  assign ev_load_lit   = act && od_op == OP_SET &&
                         (od_tgt == TGT_W'(TGT_DL_ZERO) || od_tgt == TGT_W'(TGT_DL_ONES));
  assign ev_set_ack    = act && od_op == OP_SET && od_tgt == TGT_W'(TGT_ACK);
  assign ev_capture    = act && od_op == OP_MOVE && od_cap;
  assign ev_route_imm  = act && od_op == OP_MOVE && od_route == ROUTE_IMM;
  assign ev_route_data = act && od_op == OP_MOVE && od_route == ROUTE_DATA;
  assign route_next    = ev_route_data ? data_in[WORD_W-1 -: ROUTE_W] : od_lit[ROUTE_W-1:0];

  lpl_data_latch #(.WORD_W(WORD_W), .SHIFT_W(SHIFT_W)) u_data (
    .clk(clk), .rst_n(rst_n), .ev_shift(ev_shift), .ev_load_lit(ev_load_lit),
    .ev_capture(ev_capture), .lit(od_lit), .data_in(data_in), .q(data_latch)
  );

  lpl_route_latch #(.W(ROUTE_W)) u_route (
    .clk(clk), .rst_n(rst_n), .load(ev_route_imm || ev_route_data),
    .value(route_next), .q(route_latch)
  );

  lpl_route_latch #(.W(ROUTE_W)) u_ack (
    .clk(clk), .rst_n(rst_n), .load(ev_set_ack),
    .value(od_lit[ROUTE_W-1:0]), .q(ack_route_latch)
  );

  assert_class_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_shift, ev_load_lit, ev_set_ack, ev_capture || ev_route_imm || ev_route_data}));
  assert_dispatch_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_route_data |=> route_latch == $past(data_in[WORD_W-1 -: ROUTE_W]));
  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_fire |=> ($stable(data_latch) && $stable(route_latch) && $stable(ack_route_latch)));
endmodule

// File: tb/sim_lpl_latch_updater.sv
module sim_lpl_latch_updater;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        deck_load = 1'b0;
  logic [25:0] insn_in = '0;
  logic        exec_fire = 1'b0;
  logic [36:0] data_in = '0;
  logic [36:0] data_latch;
  logic [12:0] route_latch, ack_route_latch;

  always #10 clk = ~clk;

  lpl_latch_updater u0 (
    .clk(clk), .rst_n(rst_n), .deck_load(deck_load), .insn_in(insn_in),
    .exec_fire(exec_fire), .data_in(data_in), .data_latch(data_latch),
    .route_latch(route_latch), .ack_route_latch(ack_route_latch)
  );

  int tests = 0, fails = 0;
  bit done = 0;
  logic [36:0] m_dl;
  logic [12:0] m_rt, m_ack;

  localparam int NV = 13;
  localparam logic [86:0] VEC [NV] = '{
    {"R2 ", 26'h005A5A5, 37'h0},
    {"R2 ", 26'h007FFFF, 37'h0},
    {"R3 ", 26'h1001ABC, 37'h0},
    {"R2 ", 26'h0000001, 37'h0},
    {"R4 ", 26'h1080123, 37'h0},
    {"R7 ", 26'h2002F0F, 37'h0},
    {"R8 ", 26'h2004000, 37'h1ABCDEF012},
    {"R9 ", 26'h2008000, 37'h0F00001234},
    {"R9 ", 26'h200A0AA, 37'h1555555555},
    {"R10", 26'h1101555, 37'h0},
    {"R12", 26'h3FFFFFF, 37'h1FFFFFFFFF},
    {"R12", 26'h1FFFFFF, 37'h1FFFFFFFFF},
    {"R9 ", 26'h2000000, 37'h1234567890}
  };

  task automatic check(input string req, input logic [36:0] act, input logic [36:0] exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, data_latch, m_dl, "data_latch");
    check(req, {24'b0, route_latch}, {24'b0, m_rt}, "route_latch");
    check(req, {24'b0, ack_route_latch}, {24'b0, m_ack}, "ack_route_latch");
  endtask

  task automatic model(input logic [25:0] w, input logic [36:0] d);
    case (w[25:24])
      2'b00: m_dl = (m_dl << 19) | {18'b0, w[18:0]};
      2'b01: case (w[23:19])
        5'd0: m_dl = {24'b0, w[12:0]};
        5'd1: m_dl = 37'h1FFFFFE000 | {24'b0, w[12:0]};
        5'd2: m_ack = w[12:0];
        default: ;
      endcase
      2'b10: begin
        if (w[15]) m_dl = d;
        if (w[14:13] == 2'b01) m_rt = w[12:0];
        else if (w[14:13] == 2'b10) m_rt = 13'(d >> 24);
      end
      default: ;
    endcase
  endtask

  task automatic run(input logic [25:0] w, input logic [36:0] d);
    @(negedge clk); deck_load = 1; insn_in = w; exec_fire = 0;
    @(negedge clk); deck_load = 0; exec_fire = 1; data_in = d;
    @(negedge clk); exec_fire = 0;
    model(w, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    m_dl = '0; m_rt = '0; m_ack = '0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1;
    @(negedge clk);
    check_all("R1");

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][62:37], VEC[i][36:0]);
      check_all(string'(VEC[i][86:63]));
    end

    // R5: insn_in changes in the execute cycle; the captured one must win
    @(negedge clk); deck_load = 1; insn_in = 26'h1000777;
    @(negedge clk); deck_load = 0; insn_in = 26'h1081FFF; exec_fire = 1;
    @(negedge clk); exec_fire = 0;
    m_dl = 37'h777;
    check_all("R5");

    // R6: deck_load without execution, then replaced
    @(negedge clk); deck_load = 1; insn_in = 26'h0012345;
    @(negedge clk); deck_load = 0;
    @(negedge clk);
    check_all("R6");
    run(26'h1000042, 37'h0);
    check_all("R6");

    // R11: stray fire with empty deck, and a repeated fire after a shift
    @(negedge clk); exec_fire = 1;
    @(negedge clk); exec_fire = 0;
    check_all("R11");
    @(negedge clk); deck_load = 1; insn_in = 26'h0000003;
    @(negedge clk); deck_load = 0; exec_fire = 1;
    @(negedge clk);
    @(negedge clk); exec_fire = 0;
    model(26'h0000003, 37'h0);
    check_all("R11");

    // R1: reset again mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    m_dl = '0; m_rt = '0; m_ack = '0;
    check_all("R1");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule